// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits behind two 10-bit pipelined conversion cores that share one sampling clock. For each channel it carries the raw conversion word and its over-range indication through a fixed six-stage pipeline. At the last stage it applies the chosen output coding, either offset binary or two's complement, or replaces the word with a forced all-ones or all-zeros test pattern. The two channels leave the block on separate parallel buses that update on the same clock edge.

Each channel has its own data-valid level, over-range flag and output-enable. Data-valid rises only once a channel's pipeline holds words captured since reset or since the channel was last powered up. A channel can be powered down by its own control, and a global control powers down both channels. Pad tri-stating is represented by an output-enable signal that follows the per-channel high-impedance request with a two-clock delay.

Top module: `adc_pair_formatter`

## Requirements
- R1: While reset is asserted, both data buses read 0, both data-valid and both over-range outputs are low, and both output-enables are high.
- R2: A raw word applied at a rising edge appears on its channel's data bus directly after the sixth rising edge, counting the capture edge as the first. With format select low and no pattern it is unchanged (offset binary).
- R3: The two channels are captured on the same edges and update their buses on the same edge, each carrying its own channel's word.
- R4: With format select high the most significant output bit is inverted: raw 512 gives 0, raw 0 gives 0x200 (-512), and raw 1023 gives 0x1FF. The setting applies to the word loaded into the output stage at the next edge.
- R5: Pattern select 2'b01 forces every data bit of every powered channel to 1 and 2'b10 forces every bit to 0, whatever the format select. 2'b00 and 2'b11 pass the data. The pattern shows from the edge after it is set.
- R6: The over-range flag travels with its word, with the same six-edge latency, and it is high only while that channel's data-valid is high.
- R7: After reset release or power-up, a channel's data-valid stays low for five edges and rises on the sixth. It then stays high while the channel remains powered.
- R8: Asserting a channel's power-down clears that channel's data bus, data-valid and over-range at the next edge and ignores its inputs. The other channel is unaffected.
- R9: The global power-down clears both channels at the next edge in the same way.
- R10: Each output-enable equals the inverse of its channel's high-impedance request as sampled two edges earlier. The data bus is not affected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_a_i | input | 10 | Raw conversion word, channel A |
| raw_b_i | input | 10 | Raw conversion word, channel B |
| ovr_a_i | input | 1 | Over-range indication, channel A |
| ovr_b_i | input | 1 | Over-range indication, channel B |
| twos_i | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| pattern_i | input | 2 | 01 all ones, 10 all zeros, 00/11 normal data |
| hiz_a_i | input | 1 | High-impedance request, channel A |
| hiz_b_i | input | 1 | High-impedance request, channel B |
| pd_a_i | input | 1 | Power-down, channel A |
| pd_b_i | input | 1 | Power-down, channel B |
| pd_all_i | input | 1 | Power-down of both channels |
| data_a_o | output | 10 | Output word, channel A |
| data_b_o | output | 10 | Output word, channel B |
| dv_a_o | output | 1 | Data-valid, channel A |
| dv_b_o | output | 1 | Data-valid, channel B |
| ovr_a_o | output | 1 | Aligned over-range flag, channel A |
| ovr_b_o | output | 1 | Aligned over-range flag, channel B |
| oe_a_o | output | 1 | Output-enable, channel A |
| oe_b_o | output | 1 | Output-enable, channel B |

## Verification
A table of twelve word pairs is streamed back to back, once in offset binary and once in two's complement. It covers both ends of the range, mid-scale and its neighbours, alternating bit patterns, and pairs where A and B differ or mirror each other, so a swapped channel, a wrong MSB inversion or an off-by-one latency gives a visible mismatch. Over-range bits set on scattered entries show whether the flag stays aligned with its word. Directed steps then apply each pattern code while two's complement is selected, toggle power-down per channel and globally while the inputs are kept busy, and toggle the high-impedance requests, each checked at the edge where its effect is due and one edge before.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

  // Test pattern selection; the two pass-through codes are equivalent.
  typedef enum logic [1:0] {
    PAT_PASS  = 2'b00,
    PAT_ONES  = 2'b01,
    PAT_ZEROS = 2'b10,
    PAT_PASS2 = 2'b11
  } pat_e;

endpackage

// File: rtl/code_shaper.sv
module code_shaper
  import adcfmt_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0] code_i,
  input  logic         twos_i,
  input  logic [1:0]   pat_i,
  output logic [W-1:0] code_o
);

  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] coded;
  pat_e         pat;

  always_comb begin
    pat   = pat_e'(pat_i);
    coded = twos_i ? (code_i ^ MSB_MASK) : code_i;
    // Pattern overrides after coding so it is format independent.
    unique case (pat)
      PAT_ONES:  code_o = {W{1'b1}};
      PAT_ZEROS: code_o = {W{1'b0}};
      default:   code_o = coded;
    endcase
  end

endmodule

// File: rtl/conv_lane.sv
module conv_lane #(
  parameter int W   = 10,
  parameter int LAT = 6    // must be 2 or more
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         active_i,
  input  logic [W-1:0] code_i,
  input  logic         ovr_i,
  input  logic         twos_i,
  input  logic [1:0]   pat_i,
  output logic [W-1:0] code_o,
  output logic         ovr_o,
  output logic         vld_o
);

  localparam int LAST = LAT - 1;

  logic [W-1:0] code_q [LAT];
  logic [W-1:0] code_d [LAT];
  logic [LAT-1:0] ovr_q, ovr_d;
  logic [LAT-1:0] vld_q, vld_d;
  logic           was_active_q;
  logic           stage_en;
  logic [W-1:0]   shaped;

  code_shaper #(.W(W)) u_shaper (
    .code_i (code_q[LAST-1]),
    .twos_i (twos_i),
    .pat_i  (pat_i),
    .code_o (shaped)
  );

  // Advance while powered, plus one edge after power-down to flush.
  assign stage_en = active_i | was_active_q;

  always_comb begin
    code_d[0] = code_i;
    ovr_d[0]  = ovr_i;
    vld_d[0]  = 1'b1;
    for (int i = 1; i < LAT; i++) begin
      code_d[i] = code_q[i-1];
      ovr_d[i]  = ovr_q[i-1];
      vld_d[i]  = vld_q[i-1];
    end
    code_d[LAST] = shaped;
    if (!active_i) begin
      for (int i = 0; i < LAT; i++) begin
        code_d[i] = '0;
      end
      ovr_d = '0;
      vld_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LAT; i++) begin
        code_q[i] <= '0;
      end
      ovr_q        <= '0;
      vld_q        <= '0;
      was_active_q <= 1'b0;
    end else begin
      was_active_q <= active_i;
      if (stage_en) begin
        for (int i = 0; i < LAT; i++) begin
          code_q[i] <= code_d[i];
        end
        ovr_q <= ovr_d;
        vld_q <= vld_d;
      end
    end
  end

  assign code_o = code_q[LAST];
  assign ovr_o  = ovr_q[LAST];
  assign vld_o  = vld_q[LAST];

endmodule

// File: rtl/oe_delay.sv
module oe_delay #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hiz_i,
  output logic oe_o
);

  logic [DEPTH-1:0] en_q, en_d;

  always_comb begin
    en_d = {en_q[DEPTH-2:0], ~hiz_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '1;
    end else begin
      en_q <= en_d;
    end
  end

  assign oe_o = en_q[DEPTH-1];

endmodule

// File: rtl/adc_pair_formatter.sv
module adc_pair_formatter #(
  parameter int CODE_W   = 10,
  parameter int LATENCY  = 6,
  parameter int OE_DELAY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] raw_a_i,
  input  logic [CODE_W-1:0] raw_b_i,
  input  logic              ovr_a_i,
  input  logic              ovr_b_i,
  input  logic              twos_i,
  input  logic [1:0]        pattern_i,
  input  logic              hiz_a_i,
  input  logic              hiz_b_i,
  input  logic              pd_a_i,
  input  logic              pd_b_i,
  input  logic              pd_all_i,
  output logic [CODE_W-1:0] data_a_o,
  output logic [CODE_W-1:0] data_b_o,
  output logic              dv_a_o,
  output logic              dv_b_o,
  output logic              ovr_a_o,
  output logic              ovr_b_o,
  output logic              oe_a_o,
  output logic              oe_b_o
);

  localparam int NUM_CH = 2;

  logic [CODE_W-1:0] raw_in  [NUM_CH];
  logic [CODE_W-1:0] code_out[NUM_CH];
  logic [NUM_CH-1:0] ovr_in, ovr_out, vld_out, hiz_in, pd_in, oe_out, active;

  assign raw_in[0] = raw_a_i;
  assign raw_in[1] = raw_b_i;
  assign ovr_in    = {ovr_b_i, ovr_a_i};
  assign hiz_in    = {hiz_b_i, hiz_a_i};
  assign pd_in     = {pd_b_i, pd_a_i};
  assign active    = ~(pd_in | {NUM_CH{pd_all_i}});

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    conv_lane #(.W(CODE_W), .LAT(LATENCY)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active[ch]),
      .code_i   (raw_in[ch]),
      .ovr_i    (ovr_in[ch]),
      .twos_i   (twos_i),
      .pat_i    (pattern_i),
      .code_o   (code_out[ch]),
      .ovr_o    (ovr_out[ch]),
      .vld_o    (vld_out[ch])
    );

    oe_delay #(.DEPTH(OE_DELAY)) u_oe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hiz_i  (hiz_in[ch]),
      .oe_o   (oe_out[ch])
    );
  end

  assign data_a_o = code_out[0];
  assign data_b_o = code_out[1];
  assign dv_a_o   = vld_out[0];
  assign dv_b_o   = vld_out[1];
  assign ovr_a_o  = ovr_out[0];
  assign ovr_b_o  = ovr_out[1];
  assign oe_a_o   = oe_out[0];
  assign oe_b_o   = oe_out[1];

endmodule

// File: rtl/adcfmt_checker.sv
module adcfmt_checker #(
  parameter int CODE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        pattern_i,
  input logic              hiz_a_i,
  input logic              hiz_b_i,
  input logic              pd_a_i,
  input logic              pd_b_i,
  input logic              pd_all_i,
  input logic [CODE_W-1:0] data_a_o,
  input logic [CODE_W-1:0] data_b_o,
  input logic              dv_a_o,
  input logic              dv_b_o,
  input logic              ovr_a_o,
  input logic              ovr_b_o,
  input logic              oe_a_o,
  input logic              oe_b_o
);

  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= 2'd0;
    end else if (since_rst_q != 2'd3) begin
      since_rst_q <= since_rst_q + 2'd1;
    end
  end

  assert_oe_a_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (oe_a_o == !$past(hiz_a_i, 2)));
  assert_oe_b_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (oe_b_o == !$past(hiz_b_i, 2)));

  assert_down_a_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_a_i || pd_all_i) |=> (!dv_a_o && !ovr_a_o && data_a_o == '0));
  assert_down_b_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_b_i || pd_all_i) |=> (!dv_b_o && !ovr_b_o && data_b_o == '0));

  assert_global_down_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_all_i |=> (!dv_a_o && !dv_b_o));

  assert_ovr_a_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_a_o |-> dv_a_o);
  assert_ovr_b_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_b_o |-> dv_b_o);

  assert_pattern_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_a_i && !pd_all_i && pattern_i == 2'b01) |=> (data_a_o == {CODE_W{1'b1}}));

  assert_dv_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_a_o && !pd_a_i && !pd_all_i) |=> dv_a_o);

endmodule

bind adc_pair_formatter adcfmt_checker #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pattern_i (pattern_i),
  .hiz_a_i   (hiz_a_i),
  .hiz_b_i   (hiz_b_i),
  .pd_a_i    (pd_a_i),
  .pd_b_i    (pd_b_i),
  .pd_all_i  (pd_all_i),
  .data_a_o  (data_a_o),
  .data_b_o  (data_b_o),
  .dv_a_o    (dv_a_o),
  .dv_b_o    (dv_b_o),
  .ovr_a_o   (ovr_a_o),
  .ovr_b_o   (ovr_b_o),
  .oe_a_o    (oe_a_o),
  .oe_b_o    (oe_b_o)
);

// File: tb/adc_pair_formatter_tb_top.sv
`timescale 1ns/1ps
module adc_pair_formatter_tb_top;

  typedef struct packed {
    logic [9:0] ra;
    logic [9:0] rb;
    logic       oa;
    logic       ob;
    logic [9:0] ta;   // expected two's complement, channel A
    logic [9:0] tb;   // expected two's complement, channel B
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{10'h000, 10'h3FF, 1'b1, 1'b0, 10'h200, 10'h1FF},
    '{10'h200, 10'h1FF, 1'b0, 1'b0, 10'h000, 10'h3FF},
    '{10'h1FF, 10'h200, 1'b0, 1'b0, 10'h3FF, 10'h000},
    '{10'h3FF, 10'h000, 1'b0, 1'b1, 10'h1FF, 10'h200},
    '{10'h155, 10'h2AA, 1'b0, 1'b0, 10'h355, 10'h0AA},
    '{10'h2AA, 10'h155, 1'b1, 1'b1, 10'h0AA, 10'h355},
    '{10'h001, 10'h3FE, 1'b0, 1'b0, 10'h201, 10'h1FE},
    '{10'h123, 10'h321, 1'b0, 1'b0, 10'h323, 10'h121},
    '{10'h3FF, 10'h3FF, 1'b1, 1'b1, 10'h1FF, 10'h1FF},
    '{10'h000, 10'h000, 1'b0, 1'b0, 10'h200, 10'h200},
    '{10'h080, 10'h380, 1'b0, 1'b1, 10'h280, 10'h180},
    '{10'h201, 10'h1FE, 1'b0, 1'b0, 10'h001, 10'h3FE}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [9:0] raw_a_i, raw_b_i;
  logic       ovr_a_i, ovr_b_i, twos_i;
  logic [1:0] pattern_i;
  logic       hiz_a_i, hiz_b_i, pd_a_i, pd_b_i, pd_all_i;
  logic [9:0] data_a_o, data_b_o;
  logic       dv_a_o, dv_b_o, ovr_a_o, ovr_b_o, oe_a_o, oe_b_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk_i = ~clk_i;

  adc_pair_formatter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .raw_a_i(raw_a_i), .raw_b_i(raw_b_i),
    .ovr_a_i(ovr_a_i), .ovr_b_i(ovr_b_i),
    .twos_i(twos_i), .pattern_i(pattern_i),
    .hiz_a_i(hiz_a_i), .hiz_b_i(hiz_b_i),
    .pd_a_i(pd_a_i), .pd_b_i(pd_b_i), .pd_all_i(pd_all_i),
    .data_a_o(data_a_o), .data_b_o(data_b_o),
    .dv_a_o(dv_a_o), .dv_b_o(dv_b_o),
    .ovr_a_o(ovr_a_o), .ovr_b_o(ovr_b_o),
    .oe_a_o(oe_a_o), .oe_b_o(oe_b_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_table(bit tc, bit from_reset);
    for (int s = 0; s < NV + 5; s++) begin
      if (s < NV) begin
        raw_a_i = TBL[s].ra; raw_b_i = TBL[s].rb;
        ovr_a_i = TBL[s].oa; ovr_b_i = TBL[s].ob;
      end else begin
        raw_a_i = '0; raw_b_i = '0; ovr_a_i = 1'b0; ovr_b_i = 1'b0;
      end
      step();
      if (s < 5 && from_reset) begin
        check("R7 dv low during fill A", dv_a_o, 0);
        check("R7 dv low during fill B", dv_b_o, 0);
      end
      if (s >= 5) begin
        check("R2/R3 dv A", dv_a_o, 1);
        check("R2/R3 dv B", dv_b_o, 1);
        check(tc ? "R4 data A" : "R2 data A", data_a_o, tc ? TBL[s-5].ta : TBL[s-5].ra);
        check(tc ? "R4 data B" : "R3 data B", data_b_o, tc ? TBL[s-5].tb : TBL[s-5].rb);
        check("R6 ovr A", ovr_a_o, TBL[s-5].oa);
        check("R6 ovr B", ovr_b_o, TBL[s-5].ob);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    raw_a_i = 10'h3A5; raw_b_i = 10'h15A; ovr_a_i = 1'b1; ovr_b_i = 1'b1;
    twos_i = 1'b0; pattern_i = 2'b00;
    hiz_a_i = 1'b0; hiz_b_i = 1'b0; pd_a_i = 1'b0; pd_b_i = 1'b0; pd_all_i = 1'b0;
    repeat (3) step();
    // R1 reset state
    check("R1 data A", data_a_o, 0);
    check("R1 data B", data_b_o, 0);
    check("R1 dv", {dv_a_o, dv_b_o}, 0);
    check("R1 ovr", {ovr_a_o, ovr_b_o}, 0);
    check("R1 oe", {oe_a_o, oe_b_o}, 2'b11);
    rst_ni = 1'b1;

    run_table(1'b0, 1'b1);
    twos_i = 1'b1;
    run_table(1'b1, 1'b0);

    // R5 patterns override two's complement
    raw_a_i = 10'h0F0; raw_b_i = 10'h0F0;
    pattern_i = 2'b01;
    step();
    check("R5 ones A", data_a_o, 10'h3FF);
    check("R5 ones B", data_b_o, 10'h3FF);
    pattern_i = 2'b10;
    step();
    check("R5 zeros A", data_a_o, 10'h000);
    check("R5 zeros B", data_b_o, 10'h000);
    pattern_i = 2'b11; twos_i = 1'b0;
    repeat (6) step();
    check("R5 pass code 11 A", data_a_o, 10'h0F0);
    check("R5 pass code 11 B", data_b_o, 10'h0F0);

    // R8 per-channel power-down, inputs ignored
    pd_a_i = 1'b1; ovr_a_i = 1'b1;
    step();
    check("R8 dv A down", dv_a_o, 0);
    check("R8 data A down", data_a_o, 0);
    check("R8 ovr A down", ovr_a_o, 0);
    check("R8 dv B kept", dv_b_o, 1);
    check("R8 data B kept", data_b_o, 10'h0F0);
    repeat (3) step();
    check("R8 ovr A ignored", ovr_a_o, 0);
    pd_a_i = 1'b0; ovr_a_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step();
      check("R7 dv A after power-up", dv_a_o, (k == 5) ? 1 : 0);
    end
    check("R7 data A after power-up", data_a_o, 10'h0F0);

    // R9 global power-down
    pd_all_i = 1'b1;
    step();
    check("R9 dv both", {dv_a_o, dv_b_o}, 0);
    check("R9 data both", {data_a_o, data_b_o}, 0);
    pd_all_i = 1'b0;
    repeat (6) step();
    check("R9 dv both restored", {dv_a_o, dv_b_o}, 2'b11);

    // R10 output-enable delay
    hiz_a_i = 1'b1;
    step();
    check("R10 oe A one edge", oe_a_o, 1);
    step();
    check("R10 oe A two edges", oe_a_o, 0);
    check("R10 oe B untouched", oe_b_o, 1);
    check("R10 data A still driven", data_a_o, 10'h0F0);
    hiz_a_i = 1'b0;
    step();
    check("R10 oe A release one edge", oe_a_o, 0);
    step();
    check("R10 oe A release two edges", oe_a_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule